// File: doc/BRIEF.md
# Pulse-Swallow Synthesiser Feedback Divider

This block is the feedback divider of a frequency synthesiser loop. It divides the local-oscillator clock by a 15-bit ratio N = 16·M + A. The division uses a model of a dual-modulus prescaler that divides by 16 or 17. A 4-bit swallow counter holds the prescaler at 17 for the first A prescaler periods. An 11-bit main counter ends the division cycle after M prescaler periods. The prescaler is modelled as synchronous logic clocked by the oscillator clock itself.

The control side presents a ratio word and pulses a load strobe. It pulses the strobe only once the complete 15-bit word has arrived, or when the bus transaction ends early. The divider copies the word into a holding register on that strobe, and raises any value below the legal floor of 240 to 240. The counters take the held value only at the next terminal count, so a retune never shortens the division cycle in progress. Each division cycle ends with a one-clock comparison pulse. A companion square wave toggles on every pulse, which gives a half-rate signal for test observation.

Top module: `swallow_divider`

## Requirements
- R1: The distance between consecutive `fpd_pulse` highs equals the held ratio N, in clock cycles. The swallow count A is bits [3:0] of the word and the main count M is bits [14:4], with N = 16·M + A.
- R2: When A = 0, every prescaler period is 16 clocks and the division cycle is exactly 16·M clocks.
- R3: When a word below 240 is loaded, it is held as 240. Words of 240 and above are held unchanged.
- R4: A change on `ratio_word` while `ratio_load` is low has no effect on the division ratio.
- R5: After a load during a division cycle, that cycle still completes with the old ratio. The following cycle uses the new ratio.
- R6: `fpd_pulse` is high for exactly one clock cycle per division cycle.
- R7: `fpd_half` changes state on each clock edge on which `fpd_pulse` rises, and at no other edge. Its period is therefore 2·N.
- R8: Under synchronous reset, `fpd_pulse` and `fpd_half` are low and the held ratio becomes 240. After reset is released, the first pulse comes 240 clocks later, whatever `ratio_word` holds.
- R9: The largest ratio, 32767 (M = 2047, A = 15), divides correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local-oscillator clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| ratio_word | input | 15 | Division ratio; bits [14:4] are M, bits [3:0] are A |
| ratio_load | input | 1 | One-cycle strobe: the full word is present |
| fpd_pulse | output | 1 | One-clock pulse at the end of each division cycle |
| fpd_half | output | 1 | Square wave toggling on each pulse (half rate) |

## Verification
The bench builds the divider with its default widths: a 4-bit swallow counter and an 11-bit main counter, which give a 16/17 prescaler, a floor of 240 and a ceiling of 32767. With these widths every period can be counted cycle by cycle in a short run. The run covers the floor itself and values just below and above it, a zero swallow count, a full swallow count, and one full period at the 32767 ceiling. Loads placed in the middle of a division cycle show that the cycle in progress ends on its old length.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

    // Counter widths of the pulse-swallow arrangement
    localparam int SWALLOW_W = 4;
    localparam int MAIN_W    = 11;
    localparam int RATIO_W   = SWALLOW_W + MAIN_W;

    // Prescaler low modulus; the high modulus is one more
    localparam int PRESCALE  = 1 << SWALLOW_W;
    localparam int PRE_W     = $clog2(PRESCALE + 1);

    // Smallest ratio with M >= largest A, so the swallow count never outlives M
    localparam int MIN_RATIO = PRESCALE * (PRESCALE - 1);
    localparam int MAX_RATIO = (1 << RATIO_W) - 1;

    typedef struct packed {
        logic [MAIN_W-1:0]    main;
        logic [SWALLOW_W-1:0] swallow;
    } ratio_t;

    function automatic ratio_t clamp_ratio(logic [RATIO_W-1:0] word);
        if (word < RATIO_W'(MIN_RATIO))
            return ratio_t'(RATIO_W'(MIN_RATIO));
        return ratio_t'(word);
    endfunction

    localparam ratio_t RESET_RATIO = ratio_t'(RATIO_W'(MIN_RATIO));

endpackage

// File: rtl/swdiv_ratio_reg.sv
module swdiv_ratio_reg
    import swdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic [RATIO_W-1:0] word_i,
    output ratio_t             held_o
);

    always_ff @(posedge clk) begin
        if (rst)
            held_o <= RESET_RATIO;
        else if (load_i)
            held_o <= clamp_ratio(word_i);
    end

endmodule

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler
    import swdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic swallow_i,   // high: divide by PRESCALE+1
    output logic wrap_o
);

    logic [PRE_W-1:0] phase;
    logic [PRE_W-1:0] last;

    assign last   = swallow_i ? PRE_W'(PRESCALE) : PRE_W'(PRESCALE - 1);
    assign wrap_o = (phase == last);

    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else if (wrap_o)
            phase <= '0;
        else
            phase <= phase + PRE_W'(1);
    end

endmodule

// File: rtl/swdiv_counters.sv
module swdiv_counters
    import swdiv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wrap_i,
    input  ratio_t               held_i,
    output logic                 swallow_o,
    output logic                 terminal_o,
    output logic [SWALLOW_W-1:0] a_left_o,
    output logic [MAIN_W-1:0]    m_left_o
);

    assign swallow_o  = (a_left_o != '0);
    assign terminal_o = wrap_i && (m_left_o == MAIN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            a_left_o <= RESET_RATIO.swallow;
            m_left_o <= RESET_RATIO.main;
        end else if (terminal_o) begin
            a_left_o <= held_i.swallow;
            m_left_o <= held_i.main;
        end else if (wrap_i) begin
            if (swallow_o)
                a_left_o <= a_left_o - SWALLOW_W'(1);
            m_left_o <= m_left_o - MAIN_W'(1);
        end
    end

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
    import swdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio_word,
    input  logic               ratio_load,
    output logic               fpd_pulse,
    output logic               fpd_half
);

    ratio_t               held;
    logic                 swallow;
    logic                 wrap;
    logic                 terminal;
    logic [SWALLOW_W-1:0] a_left;
    logic [MAIN_W-1:0]    m_left;

    swdiv_ratio_reg u_ratio (
        .clk    (clk),
        .rst    (rst),
        .load_i (ratio_load),
        .word_i (ratio_word),
        .held_o (held)
    );

    swdiv_prescaler u_pre (
        .clk       (clk),
        .rst       (rst),
        .swallow_i (swallow),
        .wrap_o    (wrap)
    );

    swdiv_counters u_cnt (
        .clk        (clk),
        .rst        (rst),
        .wrap_i     (wrap),
        .held_i     (held),
        .swallow_o  (swallow),
        .terminal_o (terminal),
        .a_left_o   (a_left),
        .m_left_o   (m_left)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fpd_pulse <= 1'b0;
            fpd_half  <= 1'b0;
        end else begin
            fpd_pulse <= terminal;
            if (terminal)
                fpd_half <= ~fpd_half;
        end
    end

endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk
    import swdiv_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 ratio_load,
    input logic                 fpd_pulse,
    input logic                 fpd_half,
    input ratio_t               held,
    input logic [SWALLOW_W-1:0] a_left,
    input logic [MAIN_W-1:0]    m_left
);

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        fpd_pulse |=> !fpd_pulse);

    a_r7_half_toggles: assert property (@(posedge clk) disable iff (rst)
        fpd_pulse |-> (fpd_half != $past(fpd_half)));

    a_r7_half_holds: assert property (@(posedge clk) disable iff (rst)
        !fpd_pulse |-> $stable(fpd_half));

    a_r3_ratio_floor: assert property (@(posedge clk) disable iff (rst)
        held >= RATIO_W'(MIN_RATIO));

    a_r4_hold_without_load: assert property (@(posedge clk) disable iff (rst)
        !ratio_load |=> $stable(held));

    a_r1_swallow_within_main: assert property (@(posedge clk) disable iff (rst)
        (a_left <= SWALLOW_W'(m_left)) || (m_left >= MAIN_W'(PRESCALE)));

    a_r8_reset_outputs: assert property (@(posedge clk)
        rst |=> (!fpd_pulse && !fpd_half));

endmodule

bind swallow_divider swallow_divider_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ratio_load (ratio_load),
    .fpd_pulse  (fpd_pulse),
    .fpd_half   (fpd_half),
    .held       (held),
    .a_left     (a_left),
    .m_left     (m_left)
);

// File: tb/swallow_divider_test.sv
`timescale 1ns/1ps
module swallow_divider_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] ratio_word = 15'd0;
    logic        ratio_load = 1'b0;
    logic        fpd_pulse;
    logic        fpd_half;

    int checks = 0;
    int errors = 0;
    logic hprev = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    swallow_divider uut (
        .clk        (clk),
        .rst        (rst),
        .ratio_word (ratio_word),
        .ratio_load (ratio_load),
        .fpd_pulse  (fpd_pulse),
        .fpd_half   (fpd_half)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts falling edges until fpd_pulse is seen high; also tracks fpd_half (R7)
    task automatic gap(output int n);
        bit half_moved = 0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (!fpd_pulse && fpd_half != hprev) half_moved = 1;
        end while (!fpd_pulse && n < 40000);
        chk(fpd_pulse == 1'b1, "R1 pulse seen before timeout", n, 0);
        chk(!half_moved && fpd_half == ~hprev, "R7 half-rate toggle", int'(fpd_half), int'(~hprev));
        hprev = fpd_half;
    endtask

    // Called right after a pulse sample: loads w, checks old then new period (R5)
    task automatic apply(input int w, input int old_n, input int exp_n, input string req);
        int n;
        @(negedge clk);
        ratio_word = 15'(w);
        ratio_load = 1'b1;
        @(negedge clk);
        ratio_load = 1'b0;
        gap(n);
        chk(n + 2 == old_n, "R5 current cycle keeps old ratio", n + 2, old_n);
        gap(n);
        chk(n == exp_n, req, n, exp_n);
    endtask

    task automatic t_reset;
        int n;
        rst = 1'b1;
        ratio_word = 15'd5000;
        repeat (4) @(negedge clk);
        chk(fpd_pulse == 1'b0, "R8 pulse low in reset", int'(fpd_pulse), 0);
        chk(fpd_half == 1'b0, "R8 half low in reset", int'(fpd_half), 0);
        rst = 1'b0;
        gap(n);
        chk(n == 240, "R8 first period from reset ratio", n, 240);
    endtask

    task automatic t_basic;
        int n;
        apply(1000, 240, 1000, "R1 ratio 1000 (M=62 A=8)");
        gap(n);
        chk(n == 1000, "R1 repeated period", n, 1000);
    endtask

    task automatic t_no_load;
        int n;
        @(negedge clk);
        ratio_word = 15'd3000;
        gap(n);
        chk(n + 1 == 1000, "R4 word change without load ignored", n + 1, 1000);
        gap(n);
        chk(n == 1000, "R4 still old ratio", n, 1000);
    endtask

    task automatic t_swallow;
        apply(4096, 1000, 4096, "R2 A=0 gives 16*M");
        apply(4111, 4096, 4111, "R1 A=15 M=256");
    endtask

    task automatic t_clamp;
        apply(100, 4111, 240, "R3 100 clamped to 240");
        apply(0, 240, 240, "R3 0 clamped to 240");
        apply(239, 240, 240, "R3 239 clamped to 240");
        apply(241, 240, 241, "R3 241 kept");
    endtask

    task automatic t_max;
        apply(32767, 241, 32767, "R9 ratio 32767");
        apply(1000, 32767, 1000, "R5 return from max");
    endtask

    task automatic t_width;
        int n;
        @(negedge clk);
        chk(fpd_pulse == 1'b0, "R6 pulse one clock wide", int'(fpd_pulse), 0);
        gap(n);
        chk(n + 1 == 1000, "R6 period after width check", n + 1, 1000);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_no_load();
        t_swallow();
        t_clamp();
        t_max();
        t_width();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all-requirements actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule